// File: doc/BRIEF.md
# Ripple-Borrow Subtractor with Result Flags

This block subtracts one unsigned byte from another without any clock. A row of identical one-bit borrow cells computes the difference. Each cell passes its borrow to the next more significant cell, the way a carry moves along an adder. The block does not add the two's complement of the subtrahend.

Two indicator outputs go with the difference:
- a zero flag, for a result of exactly zero;
- a negative flag, for a minuend smaller than the subtrahend.

When the result would be negative, the difference output wraps modulo 256.

The operand width is a parameter, with a default of eight bits. Surrounding logic uses the block as a comparator and subtractor in one. It can take the flags as branch conditions and the difference as a plain value.

Top module: `ripple_borrow_sub`

## Requirements
- R1: With both operands at 0, diff is 0, zeroFlag is 1, negFlag is 0 and borrowOut is 0.
- R2: For every pair of 8-bit unsigned operands (0 to 255), diff equals (opA - opB) modulo 256.
- R3: borrowOut, the borrow leaving the most significant cell, is 1 exactly when opA < opB.
- R4: zeroFlag is 1 exactly when all 8 bits of diff are 0, which is the case exactly when opA equals opB.
- R5: negFlag is 1 exactly when opA < opB, and it always equals borrowOut.
- R6: 230 - 45 gives 185 with both flags clear. 187 - 177 gives 10 with both flags clear. 177 - 187 gives 246 with negFlag set.
- R7: 0 - 255 gives 1 with negFlag set. 255 - 0 gives 255 with both flags clear.
- R8: Each 1-bit cell gives d = a XOR b XOR bin and a borrow-out of 1 when a - b - bin < 0. The borrow into the least significant cell is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | Minuend, unsigned |
| opB | input | 8 | Subtrahend, unsigned |
| diff | output | 8 | Difference, modulo 256 |
| borrowOut | output | 1 | Borrow from the most significant cell |
| zeroFlag | output | 1 | Difference is all zeros |
| negFlag | output | 1 | Minuend smaller than subtrahend |

## Verification
The bench covers every operand pair, and a seeded random pass and the directed points come on top of that.

Each corner case targets a likely fault:
- The borrow chain is fully exercised by 0 - 255, 255 - 0 and pairs such as 128 - 1. A cell that drops its borrow-in, or an unwired borrow link, gives a difference that is off by a power of two in the upper bits.
- Equal operands and pairs that differ by one around the wrap separate a zero flag from a negative flag. A zero flag decoded from the wrong bits, or a negative flag taken from diff bit 7 and not from the final borrow, fails at pairs such as 200 - 10.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int unsigned DefaultWidth = 8;

  typedef struct packed {
    logic zero;
    logic neg;
  } rbs_flags_t;
endpackage

// File: rtl/rbs_cell.sv
module rbs_cell (
  input  logic a,
  input  logic b,
  input  logic bin,
  output logic d,
  output logic bout
);
  always_comb begin
    d    = a ^ b ^ bin;
    bout = (~a & b) | (~a & bin) | (b & bin);
  end

  // R8: weight check a - b - bin == d - 2*bout
  always_comb begin
    assert_cell_weight_R8: assert ((int'(a) - int'(b) - int'(bin)) == (int'(d) - 2 * int'(bout)))
      else $error("cell arithmetic mismatch");
  end
endmodule

// File: rtl/rbs_chain.sv
module rbs_chain #(
  parameter int unsigned Width = rbs_pkg::DefaultWidth
) (
  input  logic [Width-1:0] minuend,
  input  logic [Width-1:0] subtrahend,
  output logic [Width-1:0] result,
  output logic             borrowMsb
);
  localparam int unsigned LinkCount = Width + 1;

  logic [LinkCount-1:0] borrowLink;

  assign borrowLink[0] = 1'b0;

  for (genvar i = 0; i < Width; i++) begin : g_cell
    rbs_cell u_cell (
      .a   (minuend[i]),
      .b   (subtrahend[i]),
      .bin (borrowLink[i]),
      .d   (result[i]),
      .bout(borrowLink[i+1])
    );
  end

  assign borrowMsb = borrowLink[LinkCount-1];
endmodule

// File: rtl/rbs_flags.sv
module rbs_flags #(
  parameter int unsigned Width = rbs_pkg::DefaultWidth
) (
  input  logic [Width-1:0]  result,
  input  logic              borrowMsb,
  output rbs_pkg::rbs_flags_t flags
);
  always_comb begin
    flags.zero = ~(|result);
    flags.neg  = borrowMsb;
  end

  // R4/R5: a zero result can never come with a borrow
  always_comb begin
    assert_zero_not_neg_R4: assert (!(flags.zero && flags.neg))
      else $error("zero and negative together");
  end
endmodule

// File: rtl/ripple_borrow_sub.sv
module ripple_borrow_sub #(
  parameter int unsigned Width = rbs_pkg::DefaultWidth
) (
  input  logic [Width-1:0] opA,
  input  logic [Width-1:0] opB,
  output logic [Width-1:0] diff,
  output logic             borrowOut,
  output logic             zeroFlag,
  output logic             negFlag
);
  logic [Width-1:0]    chainResult;
  logic                chainBorrow;
  rbs_pkg::rbs_flags_t flagBits;

  rbs_chain #(.Width(Width)) u_chain (
    .minuend   (opA),
    .subtrahend(opB),
    .result    (chainResult),
    .borrowMsb (chainBorrow)
  );

  rbs_flags #(.Width(Width)) u_flags (
    .result   (chainResult),
    .borrowMsb(chainBorrow),
    .flags    (flagBits)
  );

  assign diff      = chainResult;
  assign borrowOut = chainBorrow;
  assign zeroFlag  = flagBits.zero;
  assign negFlag   = flagBits.neg;

  always_comb begin
    assert_diff_mod_R2: assert (((diff + opB) & {Width{1'b1}}) == opA)
      else $error("difference wrong");
    assert_borrow_lt_R3: assert (borrowOut == (opA < opB))
      else $error("borrow wrong");
    assert_zero_eq_R4: assert (zeroFlag == (opA == opB))
      else $error("zero flag wrong");
    assert_neg_lt_R5: assert (negFlag == (opA < opB))
      else $error("negative flag wrong");
  end
endmodule

// File: tb/ripple_borrow_sub_tb.sv
module ripple_borrow_sub_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] opA, opB, diff;
  logic borrowOut, zeroFlag, negFlag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ripple_borrow_sub u_dut (
    .opA(opA), .opB(opB), .diff(diff),
    .borrowOut(borrowOut), .zeroFlag(zeroFlag), .negFlag(negFlag)
  );

  function automatic logic [7:0] expDiff(input int a, input int b);
    return 8'((a - b + 256) % 256);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s A=%0d B=%0d actual=%0d expected=%0d", tag, opA, opB, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input string tag);
    @(negedge clk);
    opA = 8'(a);
    opB = 8'(b);
    #5;
    check({tag, " R2 diff"}, int'(diff), int'(expDiff(a, b)));
    check({tag, " R3 borrow"}, int'(borrowOut), (a < b) ? 1 : 0);
    check({tag, " R4 zero"}, int'(zeroFlag), (a == b) ? 1 : 0);
    check({tag, " R5 neg"}, int'(negFlag), (a < b) ? 1 : 0);
    check({tag, " R5 neg==borrow"}, int'(negFlag), int'(borrowOut));
  endtask

  initial begin
    opA = 8'd0;
    opB = 8'd0;
    #5;
    // R1: both operands at zero
    check("R1 diff", int'(diff), 0);
    check("R1 zero", int'(zeroFlag), 1);
    check("R1 neg", int'(negFlag), 0);
    check("R1 borrow", int'(borrowOut), 0);

    // R6: the three worked examples
    apply(230, 45, "R6");
    check("R6 230-45", int'(diff), 185);
    apply(187, 177, "R6");
    check("R6 187-177", int'(diff), 10);
    apply(177, 187, "R6");
    check("R6 177-187", int'(diff), 246);
    check("R6 177-187 neg", int'(negFlag), 1);

    // R7: extreme operands
    apply(0, 255, "R7");
    check("R7 0-255", int'(diff), 1);
    check("R7 0-255 neg", int'(negFlag), 1);
    apply(255, 0, "R7");
    check("R7 255-0", int'(diff), 255);
    check("R7 255-0 neg", int'(negFlag), 0);
    apply(128, 1, "R7");
    apply(200, 10, "R7");

    // R2 and R8: seeded random pass
    void'($urandom(32'd1234));
    for (int n = 0; n < 2000; n++) begin
      int ra = int'($urandom_range(255, 0));
      int rb = int'($urandom_range(255, 0));
      apply(ra, rb, "R8 rand");
    end

    // R2: every operand pair
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply(a, b, "R2 exh");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule